// File: doc/BRIEF.md
# Video Ancillary Data Flag Generator

This block sits behind a video deserializer and receives 10-bit words, one per pixel clock. In HD mode two words arrive together, one on the luma channel and one on the chroma channel. In SD mode the luma input carries a single multiplexed Y/Cb/Cr stream. The block looks for ancillary data packets anywhere in the stream, in horizontal or vertical blanking. It passes the video words through, and beside each word it drives a flag that is high when that word belongs to a packet. Downstream logic can use the flags directly as clock enables, or as write enables into a FIFO.

A packet opens with the three-word flag pattern 000, 3FF, 3FF. Three header words follow: data ID, secondary data ID and data count. Then come as many user words as the data count gives, and the packet ends with one checksum word. The block also watches for the timing reference 3FF, 000, 000 followed by a status word. When that status word marks start of active video, the block raises a one-clock load strobe. The strobe lines up with the status word on the output. A timing reference that turns up inside a packet ends the packet.

Top module: `anc_flag_gen`

## Requirements
- R1: In HD mode (`sd_mode` = 0), `luma_anc` is high on exactly the output words of a luma packet: from the first flag word 000 through the checksum word.
- R2: In HD mode, `chroma_anc` marks chroma packets in the same way. The chroma flag is independent of the luma flag, so packets on the two channels may overlap in time.
- R3: The packet length is taken from the low 8 bits of the data-count word, giving 0 to 255 user words. With a count of 0 the packet is 7 words long. With a count of 255 it is 262 words long.
- R4: Detection does not depend on line timing. A packet is flagged whether it follows an end-of-active-video reference (horizontal blanking) or appears with no timing reference nearby (vertical blanking).
- R5: In SD mode (`sd_mode` = 1), packets are found on `luma_in` only and flagged on `luma_anc`. `chroma_anc` stays low even when `chroma_in` carries a flag pattern.
- R6: If a timing reference 3FF, 000, 000 arrives while a packet is open, the packet is aborted. None of the reference words, and no word after them, is flagged until a new flag pattern appears.
- R7: `load_pulse` is high for one clock, aligned with a status word on `luma_out`, when that status word follows 3FF, 000, 000 and has bit 9 = 1 and bit 4 = 0 (start of active video). A status word with bit 4 = 1 (end of active video) produces no pulse.
- R8: A synchronous active-high `rst` clears detection. At the first edge with `rst` high, `luma_anc`, `chroma_anc`, `load_pulse`, `luma_out` and `chroma_out` all go to 0. A packet that was open when reset came is forgotten.
- R9: `luma_out` and `chroma_out` repeat `luma_in` and `chroma_in` delayed by three clock edges. Each flag and the strobe are aligned with the word they describe.
- R10: Packets that follow each other with no gap are flagged continuously, with no low cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_mode | input | 1 | 1 = SD single multiplexed channel, 0 = HD luma/chroma pair |
| luma_in | input | 10 | Luma word (HD) or multiplexed word (SD) |
| chroma_in | input | 10 | Chroma word (HD) |
| luma_out | output | 10 | `luma_in` delayed by three clocks |
| chroma_out | output | 10 | `chroma_in` delayed by three clocks |
| luma_anc | output | 1 | Packet flag for `luma_out` |
| chroma_anc | output | 1 | Packet flag for `chroma_out` (low in SD) |
| load_pulse | output | 1 | One-clock strobe on a start-of-active-video status word |

## Verification
A word presented before a rising edge reaches `luma_out`/`chroma_out` on the third rising edge, counting that one. Its flag and any load strobe appear on the same edge, because each travels through three registers alongside the data. The table walker therefore samples 1 ns after every edge and compares the outputs with the vector presented two table steps earlier. The directed tests work the same way: after a reset, a long packet or an aborted packet, they keep feeding words and sampling for at least three more edges before judging the flags. The reset check is the one exception. It samples right after the edge on which reset is taken, since reset clears the output registers directly.

// File: rtl/anc_flag_gen.sv
module anc_flag_gen #(
  parameter int W     = 10,
  parameter int CNT_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sd_mode,
  input  logic [W-1:0] luma_in,
  input  logic [W-1:0] chroma_in,
  output logic [W-1:0] luma_out,
  output logic [W-1:0] chroma_out,
  output logic         luma_anc,
  output logic         chroma_anc,
  output logic         load_pulse
);
  localparam int NCH = 2;
  localparam int HB  = W - 6;
  localparam logic [W-1:0] ONES  = '1;
  localparam logic [W-1:0] ZEROS = '0;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  typedef enum logic [2:0] {S_IDLE, S_DID, S_SDID, S_DCNT, S_USER, S_CSUM} st_t;

  logic [W-1:0]     din [NCH];
  logic [W-1:0]     d1  [NCH];
  logic [W-1:0]     d2  [NCH];
  logic [W-1:0]     d3  [NCH];
  st_t              st  [NCH];
  logic [CNT_W-1:0] cnt [NCH];
  logic [NCH-1:0]   en, adf, trs, mark, m1, m2, m3;
  logic             xyz_sav, p1, p2, p3;

  assign din[0] = luma_in;
  assign din[1] = chroma_in;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      en[c]   = (c == 0) ? 1'b1 : !sd_mode;
      trs[c]  = din[c] == ZEROS && d1[c] == ZEROS && d2[c] == ONES;
      adf[c]  = en[c] && st[c] == S_IDLE &&
                d2[c] == ZEROS && d1[c] == ONES && din[c] == ONES;
      mark[c] = en[c] && st[c] != S_IDLE && !trs[c];
    end
  end

  assign xyz_sav = d3[0] == ONES && d2[0] == ZEROS && d1[0] == ZEROS &&
                   luma_in[W-1] && !luma_in[HB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        d1[c]  <= '0;
        d2[c]  <= '0;
        d3[c]  <= '0;
        st[c]  <= S_IDLE;
        cnt[c] <= '0;
      end
      m1 <= '0;
      m2 <= '0;
      m3 <= '0;
      p1 <= 1'b0;
      p2 <= 1'b0;
      p3 <= 1'b0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        d1[c] <= din[c];
        d2[c] <= d1[c];
        d3[c] <= d2[c];
        if (!en[c] || trs[c]) begin
          st[c] <= S_IDLE;
          m1[c] <= 1'b0;
          m2[c] <= 1'b0;
          m3[c] <= 1'b0;
        end else begin
          m1[c] <= mark[c] | adf[c];
          m2[c] <= m1[c] | adf[c];
          m3[c] <= m2[c] | adf[c];
          case (st[c])
            S_IDLE: if (adf[c]) st[c] <= S_DID;
            S_DID:  st[c] <= S_SDID;
            S_SDID: st[c] <= S_DCNT;
            S_DCNT: begin
              cnt[c] <= din[c][CNT_W-1:0];
              st[c]  <= (din[c][CNT_W-1:0] == CNT_ZERO) ? S_CSUM : S_USER;
            end
            S_USER: begin
              cnt[c] <= cnt[c] - CNT_ONE;
              if (cnt[c] == CNT_ONE) st[c] <= S_CSUM;
            end
            S_CSUM:  st[c] <= S_IDLE;
            default: st[c] <= S_IDLE;
          endcase
        end
      end
      p1 <= xyz_sav;
      p2 <= p1;
      p3 <= p2;
    end
  end

  assign luma_out   = d3[0];
  assign chroma_out = d3[1];
  assign luma_anc   = m3[0];
  assign chroma_anc = m3[1];
  assign load_pulse = p3;
endmodule

module anc_flag_gen_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         sd_mode,
  input logic [W-1:0] luma_out,
  input logic [W-1:0] chroma_out,
  input logic         luma_anc,
  input logic         chroma_anc,
  input logic         load_pulse
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  a_r1_luma_starts_on_flag_word: assert property (@(posedge clk) disable iff (rst)
    $rose(luma_anc) |-> luma_out == '0);

  a_r2_chroma_starts_on_flag_word: assert property (@(posedge clk) disable iff (rst)
    $rose(chroma_anc) |-> chroma_out == '0);

  a_r5_sd_chroma_quiet: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0) && $past(sd_mode) |-> !chroma_anc);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse);

  a_r7_pulse_on_sav: assert property (@(posedge clk) disable iff (rst)
    load_pulse && warm == 2'd3 |->
      luma_out[W-1] && !luma_out[W-6] && $past(luma_out, 1) == '0 &&
      $past(luma_out, 2) == '0 && $past(luma_out, 3) == '1);

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !luma_anc && !chroma_anc && !load_pulse);
endmodule

bind anc_flag_gen anc_flag_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sd_mode(sd_mode), .luma_out(luma_out),
  .chroma_out(chroma_out), .luma_anc(luma_anc), .chroma_anc(chroma_anc),
  .load_pulse(load_pulse)
);

// File: tb/anc_flag_gen_bench.sv
module anc_flag_gen_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       sd_mode;
  logic [9:0] luma_in, chroma_in, luma_out, chroma_out;
  logic       luma_anc, chroma_anc, load_pulse;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  anc_flag_gen u_anc_flag_gen (
    .clk(clk), .rst(rst), .sd_mode(sd_mode), .luma_in(luma_in),
    .chroma_in(chroma_in), .luma_out(luma_out), .chroma_out(chroma_out),
    .luma_anc(luma_anc), .chroma_anc(chroma_anc), .load_pulse(load_pulse)
  );

  // {sd, luma, chroma, exp luma flag, exp chroma flag, exp load}
  localparam int N = 57;
  localparam logic [23:0] TBL [N] = '{
    {1'b0,10'h040,10'h200,3'b000},
    {1'b0,10'h3FF,10'h3FF,3'b000},
    {1'b0,10'h000,10'h000,3'b000},
    {1'b0,10'h000,10'h000,3'b000},
    {1'b0,10'h274,10'h274,3'b000},  // R7 end-of-active status: no pulse
    {1'b0,10'h000,10'h040,3'b100},  // R4 packet in horizontal blanking
    {1'b0,10'h3FF,10'h040,3'b100},
    {1'b0,10'h3FF,10'h040,3'b100},
    {1'b0,10'h241,10'h000,3'b110},  // R2 overlapping chroma packet
    {1'b0,10'h101,10'h3FF,3'b110},
    {1'b0,10'h102,10'h3FF,3'b110},
    {1'b0,10'h1AA,10'h241,3'b110},
    {1'b0,10'h155,10'h101,3'b110},
    {1'b0,10'h12C,10'h200,3'b110},  // R3 chroma count 200 -> low 8 bits 0
    {1'b0,10'h040,10'h1E5,3'b010},
    {1'b0,10'h040,10'h040,3'b000},
    {1'b0,10'h000,10'h040,3'b100},  // R10 first of two back-to-back packets
    {1'b0,10'h3FF,10'h040,3'b100},
    {1'b0,10'h3FF,10'h040,3'b100},
    {1'b0,10'h241,10'h040,3'b100},
    {1'b0,10'h101,10'h040,3'b100},
    {1'b0,10'h200,10'h040,3'b100},
    {1'b0,10'h1C3,10'h040,3'b100},
    {1'b0,10'h000,10'h040,3'b100},  // R10 second packet, no gap
    {1'b0,10'h3FF,10'h040,3'b100},
    {1'b0,10'h3FF,10'h040,3'b100},
    {1'b0,10'h241,10'h040,3'b100},
    {1'b0,10'h101,10'h040,3'b100},
    {1'b0,10'h101,10'h040,3'b100},
    {1'b0,10'h080,10'h040,3'b100},
    {1'b0,10'h200,10'h040,3'b100},
    {1'b0,10'h040,10'h040,3'b000},
    {1'b0,10'h000,10'h040,3'b100},  // R6 packet cut by a timing reference
    {1'b0,10'h3FF,10'h040,3'b100},
    {1'b0,10'h3FF,10'h040,3'b100},
    {1'b0,10'h241,10'h040,3'b100},
    {1'b0,10'h101,10'h040,3'b100},
    {1'b0,10'h110,10'h040,3'b100},
    {1'b0,10'h080,10'h040,3'b100},
    {1'b0,10'h3FF,10'h3FF,3'b000},
    {1'b0,10'h000,10'h000,3'b000},
    {1'b0,10'h000,10'h000,3'b000},
    {1'b0,10'h200,10'h200,3'b001},  // R7 start-of-active status: pulse
    {1'b0,10'h040,10'h040,3'b000},
    {1'b0,10'h040,10'h040,3'b000},
    {1'b1,10'h040,10'h040,3'b000},  // R5 SD mode from here
    {1'b1,10'h000,10'h000,3'b100},
    {1'b1,10'h3FF,10'h3FF,3'b100},
    {1'b1,10'h3FF,10'h3FF,3'b100},
    {1'b1,10'h241,10'h241,3'b100},
    {1'b1,10'h101,10'h101,3'b100},
    {1'b1,10'h101,10'h101,3'b100},
    {1'b1,10'h0AA,10'h0AA,3'b100},
    {1'b1,10'h123,10'h123,3'b100},
    {1'b1,10'h040,10'h040,3'b000},
    {1'b1,10'h040,10'h040,3'b000},
    {1'b1,10'h040,10'h040,3'b000}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic sd, input logic [9:0] l, input logic [9:0] c);
    sd_mode = sd; luma_in = l; chroma_in = c;
    @(posedge clk); #1;
  endtask

  initial begin
    #(20 * 5000);
    chk("watchdog", 1, 0);
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int flagged;
    logic [23:0] e;
    rst = 1'b1; sd_mode = 1'b0; luma_in = 10'h040; chroma_in = 10'h040;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset luma flag", luma_anc, 0);
    chk("R8 reset chroma flag", chroma_anc, 0);
    chk("R8 reset load", load_pulse, 0);
    chk("R8 reset luma data", luma_out, 0);
    rst = 1'b0;

    for (int j = 0; j < N; j++) begin
      drive(TBL[j][23], TBL[j][22:13], TBL[j][12:3]);
      if (j >= 2) begin
        e = TBL[j-2];
        chk("R1 luma flag", luma_anc, e[2]);
        chk(e[23] ? "R5 chroma flag" : "R2 chroma flag", chroma_anc, e[1]);
        chk("R7 load pulse", load_pulse, e[0]);
        chk("R9 luma data", luma_out, e[22:13]);
        chk("R9 chroma data", chroma_out, e[12:3]);
      end
    end

    // R3: count 2FF -> 255 user words, 262 flagged words in total
    flagged = 0;
    drive(1'b0, 10'h040, 10'h040);
    drive(1'b0, 10'h040, 10'h040);
    drive(1'b0, 10'h040, 10'h040);
    drive(1'b0, 10'h000, 10'h040); flagged += luma_anc;
    drive(1'b0, 10'h3FF, 10'h040); flagged += luma_anc;
    drive(1'b0, 10'h3FF, 10'h040); flagged += luma_anc;
    drive(1'b0, 10'h241, 10'h040); flagged += luma_anc;
    drive(1'b0, 10'h101, 10'h040); flagged += luma_anc;
    drive(1'b0, 10'h2FF, 10'h040); flagged += luma_anc;
    for (int k = 0; k < 255; k++) begin
      drive(1'b0, 10'h080, 10'h040); flagged += luma_anc;
    end
    drive(1'b0, 10'h155, 10'h040); flagged += luma_anc;
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, 10'h040, 10'h040); flagged += luma_anc;
    end
    chk("R3 long packet length", flagged, 262);
    chk("R3 flag low after long packet", luma_anc, 0);

    // R8: reset in the middle of a packet forgets it
    drive(1'b0, 10'h000, 10'h040);
    drive(1'b0, 10'h3FF, 10'h040);
    drive(1'b0, 10'h3FF, 10'h040);
    drive(1'b0, 10'h241, 10'h040);
    drive(1'b0, 10'h101, 10'h040);
    drive(1'b0, 10'h105, 10'h040);
    chk("R8 packet open before reset", luma_anc, 1);
    rst = 1'b1;
    drive(1'b0, 10'h080, 10'h040);
    chk("R8 flag cleared by reset", luma_anc, 0);
    chk("R8 data cleared by reset", luma_out, 0);
    rst = 1'b0;
    flagged = 0;
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 10'h080, 10'h040); flagged += luma_anc;
    end
    drive(1'b0, 10'h155, 10'h040); flagged += luma_anc;
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 10'h040, 10'h040); flagged += luma_anc;
    end
    chk("R8 no flag after reset", flagged, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule